// File: doc/BRIEF.md
# Dual-Lane Signed Halfword Adder/Subtractor

This unit splits each of two 32-bit operands into a pair of signed 16-bit halves and combines them lane by lane. A selection field taken from a 12-bit instruction word picks one of four forms. Two are straight forms, adding or subtracting matching halves. The other two are crossed forms, which pair each half of the first operand with the opposite half of the second and subtract in one lane while adding in the other.

Each lane is computed one bit wider than its inputs, so the sign of the true sum or difference is never lost. The packed 32-bit result keeps only the low 16 bits of each lane. The wide sign of each lane drives a pair of greater-or-equal bits in a status word supplied by the caller. The result and the updated status word are registered, and a one-cycle done strobe follows every accepted request.

Top module: `dual_lane_addsub`

## Requirements
- R1: When instruction bits [11:4] equal 0xF7, the low lane is A[15:0] minus B[15:0] and the high lane is A[31:16] minus B[31:16], all halves treated as signed.
- R2: When instruction bits [11:4] equal 0xF1, each lane is the signed sum of the matching halves of A and B.
- R3: When instruction bits [11:4] equal 0xF5, the low lane is A[15:0] plus B[31:16] and the high lane is A[31:16] minus B[15:0].
- R4: For every other value of instruction bits [11:4], the low lane is A[15:0] minus B[31:16] and the high lane is A[31:16] plus B[15:0].
- R5: Result bits [15:0] hold the low 16 bits of the low lane, and bits [31:16] hold the low 16 bits of the high lane.
- R6: Status bits 16 and 17 are both 1 when the 17-bit low-lane value is zero or positive, and both 0 when it is negative.
- R7: Status bits 18 and 19 are both 1 when the 17-bit high-lane value is zero or positive, and both 0 when it is negative.
- R8: Status bits [15:0] and [31:20] of the output equal those of the status input that was accepted with the request.
- R9: Result and status appear on the clock edge that follows a cycle with the valid strobe high, and done is high for exactly the cycles that follow a valid cycle.
- R10: A synchronous active-high reset sets the result, the status output and done to zero.
- R11: While the valid strobe is low, the result and status outputs keep their values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe, one cycle per operation |
| instr | input | 12 | Instruction field; bits [11:4] select the form |
| opnd_a | input | 32 | First packed operand |
| opnd_b | input | 32 | Second packed operand |
| stat_in | input | 32 | Current status word |
| res_out | output | 32 | Registered packed result |
| stat_out | output | 32 | Registered updated status word |
| done | output | 1 | One-cycle pulse marking a new result |

## Verification
On every cycle the assertions enforce the done timing, the hold of both outputs while no request is present, the pairing of each flag bit with its twin, the passage of untouched status bits, and the low lane of the straight add and subtract forms. Only the scenarios can show that the wide sign is used rather than the truncated one, through lanes that overflow 16 bits in both directions. They also show that the crossed forms route the correct halves, that unknown selector values take the second crossed form, and that a reset mid-stream clears the outputs.

// File: rtl/dlas_pkg.sv
package dlas_pkg;

    localparam int LANE_W   = 16;
    localparam int LANES    = 2;
    localparam int SEL_W    = 8;

    localparam logic [SEL_W-1:0] SEL_SUB  = 8'hF7;
    localparam logic [SEL_W-1:0] SEL_ADD  = 8'hF1;
    localparam logic [SEL_W-1:0] SEL_XASB = 8'hF5;

    // XADD_SUB: low lane adds, high lane subtracts (crossed halves)
    // XSUB_ADD: low lane subtracts, high lane adds (crossed halves)
    typedef enum logic [1:0] {
        OP_ADD      = 2'd0,
        OP_SUB      = 2'd1,
        OP_XADD_SUB = 2'd2,
        OP_XSUB_ADD = 2'd3
    } lane_op_e;

    function automatic lane_op_e decode_sel(input logic [SEL_W-1:0] sel);
        lane_op_e op;
        case (sel)
            SEL_SUB:  op = OP_SUB;
            SEL_ADD:  op = OP_ADD;
            SEL_XASB: op = OP_XADD_SUB;
            default:  op = OP_XSUB_ADD;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/dlas_route.sv
module dlas_route
    import dlas_pkg::*;
#(
    parameter int W = LANE_W
) (
    input  lane_op_e                 op,
    input  logic [2*W-1:0]           a,
    input  logic [2*W-1:0]           b,
    output logic [LANES-1:0][W-1:0]  lx,
    output logic [LANES-1:0][W-1:0]  ly,
    output logic [LANES-1:0]         lsub
);
    logic [W-1:0] a_lo, a_hi, b_lo, b_hi;

    assign a_lo = a[W-1:0];
    assign a_hi = a[2*W-1:W];
    assign b_lo = b[W-1:0];
    assign b_hi = b[2*W-1:W];

    always_comb begin
        lx[0] = a_lo;
        lx[1] = a_hi;
        case (op)
            OP_ADD: begin
                ly[0] = b_lo; ly[1] = b_hi; lsub = 2'b00;
            end
            OP_SUB: begin
                ly[0] = b_lo; ly[1] = b_hi; lsub = 2'b11;
            end
            OP_XADD_SUB: begin
                ly[0] = b_hi; ly[1] = b_lo; lsub = 2'b10;
            end
            default: begin
                ly[0] = b_hi; ly[1] = b_lo; lsub = 2'b01;
            end
        endcase
    end
endmodule

// File: rtl/dlas_lane.sv
module dlas_lane #(
    parameter int W = 16
) (
    input  logic [W-1:0]   x,
    input  logic [W-1:0]   y,
    input  logic           sub,
    output logic [W:0]     wide
);
    logic signed [W:0] xe, ye;

    assign xe   = {x[W-1], x};
    assign ye   = {y[W-1], y};
    assign wide = sub ? (xe - ye) : (xe + ye);
endmodule

// File: rtl/dual_lane_addsub.sv
module dual_lane_addsub
    import dlas_pkg::*;
#(
    parameter int W        = LANE_W,
    parameter int INSTR_W  = 12,
    parameter int FLAG_LSB = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [INSTR_W-1:0]  instr,
    input  logic [2*W-1:0]      opnd_a,
    input  logic [2*W-1:0]      opnd_b,
    input  logic [2*W-1:0]      stat_in,
    output logic [2*W-1:0]      res_out,
    output logic [2*W-1:0]      stat_out,
    output logic                done
);
    localparam int WORD_W  = 2 * W;
    localparam int SEL_LSB = INSTR_W - SEL_W;

    lane_op_e                op;
    logic [LANES-1:0][W-1:0] lx, ly;
    logic [LANES-1:0]        lsub;
    logic [LANES-1:0][W:0]   wide;
    logic [WORD_W-1:0]       res_nxt, stat_nxt;

    assign op = decode_sel(instr[INSTR_W-1:SEL_LSB]);

    dlas_route #(.W(W)) u_route (
        .op   (op),
        .a    (opnd_a),
        .b    (opnd_b),
        .lx   (lx),
        .ly   (ly),
        .lsub (lsub)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dlas_lane #(.W(W)) u_lane (
            .x    (lx[g]),
            .y    (ly[g]),
            .sub  (lsub[g]),
            .wide (wide[g])
        );
        assign res_nxt[g*W +: W] = wide[g][W-1:0];
    end

    always_comb begin
        stat_nxt = stat_in;
        for (int i = 0; i < LANES; i++) begin
            stat_nxt[FLAG_LSB + 2*i +: 2] = {2{~wide[i][W]}};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_out  <= '0;
            stat_out <= '0;
            done     <= 1'b0;
        end else begin
            done <= in_valid;
            if (in_valid) begin
                res_out  <= res_nxt;
                stat_out <= stat_nxt;
            end
        end
    end
endmodule

// File: rtl/dlas_chk.sv
module dlas_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [11:0] instr,
    input logic [31:0] opnd_a,
    input logic [31:0] opnd_b,
    input logic [31:0] stat_in,
    input logic [31:0] res_out,
    input logic [31:0] stat_out,
    input logic        done
);
    assert_done_timing_R9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (done == $past(in_valid)));

    assert_hold_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(res_out) && $stable(stat_out)));

    assert_low_pair_R6: assert property (@(posedge clk) disable iff (rst)
        stat_out[16] == stat_out[17]);

    assert_high_pair_R7: assert property (@(posedge clk) disable iff (rst)
        stat_out[18] == stat_out[19]);

    assert_passthru_R8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (stat_out[15:0] == $past(stat_in[15:0])) &&
                     (stat_out[31:20] == $past(stat_in[31:20])));

    assert_add_low_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && instr[11:4] == 8'hF1) |=>
            (res_out[15:0] == $past(opnd_a[15:0] + opnd_b[15:0])));

    assert_sub_low_R1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && instr[11:4] == 8'hF7) |=>
            (res_out[15:0] == $past(opnd_a[15:0] - opnd_b[15:0])));
endmodule

bind dual_lane_addsub dlas_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .instr    (instr),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .stat_in  (stat_in),
    .res_out  (res_out),
    .stat_out (stat_out),
    .done     (done)
);

// File: tb/dual_lane_addsub_test.sv
module dual_lane_addsub_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [11:0] instr = '0;
    logic [31:0] opnd_a = '0, opnd_b = '0, stat_in = '0;
    logic [31:0] res_out, stat_out;
    logic        done;

    int tests = 0;
    int fails = 0;
    logic [31:0] q_res[$];
    logic [31:0] q_stat[$];
    string       q_tag[$];

    always #4 clk = ~clk;

    dual_lane_addsub uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .stat_in(stat_in),
        .res_out(res_out), .stat_out(stat_out), .done(done)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    function automatic void model(input logic [11:0] ins, input logic [31:0] a, b, s,
                                  output logic [31:0] r, output logic [31:0] st);
        int al, ah, bl, bh, lo, hi;
        al = {{16{a[15]}}, a[15:0]};
        ah = {{16{a[31]}}, a[31:16]};
        bl = {{16{b[15]}}, b[15:0]};
        bh = {{16{b[31]}}, b[31:16]};
        case (ins[11:4])
            8'hF7:   begin lo = al - bl; hi = ah - bh; end
            8'hF1:   begin lo = al + bl; hi = ah + bh; end
            8'hF5:   begin lo = al + bh; hi = ah - bl; end
            default: begin lo = al - bh; hi = ah + bl; end
        endcase
        r  = {hi[15:0], lo[15:0]};
        st = s & ~32'h000F_0000;
        if (lo >= 0) st = st | 32'h0003_0000;
        if (hi >= 0) st = st | 32'h000C_0000;
    endfunction

    // Driver: called just after a falling edge; leaves at the next falling edge.
    task automatic issue(input logic [11:0] ins, input logic [31:0] a, b, s, input string tag);
        logic [31:0] er, es;
        model(ins, a, b, s, er, es);
        q_res.push_back(er);
        q_stat.push_back(es);
        q_tag.push_back(tag);
        instr = ins; opnd_a = a; opnd_b = b; stat_in = s;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: samples 2 ns after each rising edge.
    always @(posedge clk) begin
        #2;
        if (!rst && done) begin
            if (q_res.size() == 0) begin
                tests++; fails++;
                $display("FAIL R9 unexpected done actual=1 expected=0");
            end else begin
                string t;
                t = q_tag.pop_front();
                check({t, " result"}, res_out, q_res.pop_front());
                check({t, " status"}, stat_out, q_stat.pop_front());
            end
        end
    end

    initial begin
        #(8 * 50000);
        fails++;
        $display("FAIL R9 watchdog pending actual=%0d expected=0", q_res.size());
        summary();
        $finish;
    end

    initial begin
        logic [31:0] held_r, held_s;
        repeat (3) @(negedge clk);
        check("R10 reset result", res_out, 32'h0);
        check("R10 reset status", stat_out, 32'h0);
        check("R10 reset done", {31'b0, done}, 32'h0);
        rst = 1'b0;
        @(negedge clk);

        // R1 R5 R6: low lane underflows past -32768, truncates to 0x7FFF, flags clear
        issue(12'hF70, 32'h0005_8000, 32'h0003_0001, 32'h0000_0000, "R1 R6 sub underflow");
        // R2 R5 R6 R7: low lane 32768 (looks negative truncated), high lane zero
        issue(12'hF10, 32'hFFFF_7FFF, 32'h0001_0001, 32'hFFFF_FFFF, "R2 R6 add overflow");
        // R3: crossed, high lane negative
        issue(12'hF50, 32'h0004_FFF0, 32'h0100_0008, 32'h1234_5678, "R3 crossed add-sub");
        // R4: other pattern, low negative
        issue(12'h123, 32'h0004_FFF0, 32'h0100_0008, 32'hA5A0_5A5A, "R4 crossed sub-add");
        issue(12'hF30, 32'h8000_7FFF, 32'h8000_8000, 32'h000F_0000, "R4 near pattern");
        // R7: high lane -32768 - 32767 underflow
        issue(12'hF70, 32'h8000_0000, 32'h7FFF_0000, 32'hFFFF_FFFF, "R7 high underflow");
        // R6 R7: equal operands give zero, flags set
        issue(12'hF70, 32'h1234_ABCD, 32'h1234_ABCD, 32'h0000_0000, "R6 R7 zero result");
        // R8: all-ones status with negative lanes
        issue(12'hF10, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R8 passthru");
        // R3 with high lane positive overflow: 32767 - (-1)
        issue(12'hF50, 32'h7FFF_0001, 32'h0002_FFFF, 32'h0000_0000, "R3 R7 high overflow");
        repeat (2) @(negedge clk);

        // R11: other inputs change while valid is low
        held_r = res_out;
        held_s = stat_out;
        instr = 12'hF10; opnd_a = 32'h1111_2222; opnd_b = 32'h3333_4444; stat_in = 32'h0;
        repeat (3) @(negedge clk);
        check("R11 hold result", res_out, held_r);
        check("R11 hold status", stat_out, held_s);
        check("R9 done idle", {31'b0, done}, 32'h0);

        // R10: reset right after a result
        issue(12'hF10, 32'h0001_0001, 32'h0001_0001, 32'hFFFF_FFFF, "R9 before reset");
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R10 mid reset result", res_out, 32'h0);
        check("R10 mid reset status", stat_out, 32'h0);
        check("R10 mid reset done", {31'b0, done}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        issue(12'hFF0, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, "R4 zero after reset");
        repeat (3) @(negedge clk);
        check("R9 queue drained", q_res.size(), 32'h0);
        summary();
        $finish;
    end
endmodule